// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two unsigned operands by repeated subtraction. A producer offers an operand pair on a valid/ready input channel. The engine loads both values into its working registers. On each later cycle it replaces the larger value with the difference of the two, and it stops once the values match or once either value is zero. The result is then presented with a level valid flag. That flag stays high, with the result held still, until the next operand pair is taken.

The control unit is a five-state Moore machine: idle, load, shrink-x, shrink-y and done. All register enables and select lines come from the state alone. The ordering between the working values is never computed by a comparator. It comes from the carry-outs of two subtractors that form x−y and y−x in parallel. A carry of 1 means no borrow. Both carries high means equal, and only the x−y carry high means x is larger.

The input channel follows the usual valid/ready rules. The producer raises `in_valid` with stable operands and keeps both unchanged until a rising edge where `in_ready` is also high. `in_ready` never depends on `in_valid` in the same cycle. It rises one cycle after the idle engine first sees `in_valid`, and it lasts exactly one cycle. The result side has no back-pressure: the result simply waits in place until the next accepted pair.

Top module: `gcd_engine`

## Requirements
- R1: While the synchronous active-low reset is low, and on the cycle after it releases, the engine is idle with `in_ready` low and `out_valid` low. Reset also clears `out_valid` when a result is being held.
- R2: `in_ready` rises exactly one cycle after the idle engine sees `in_valid` high. It is high for exactly one cycle per accepted pair.
- R3: `in_valid` has no effect while a computation is in progress. `in_ready` stays low and the pending result is unchanged.
- R4: The clock edge at which `in_valid` and `in_ready` are both high loads `in_a` into x and `in_b` into y, and it drives `out_valid` low.
- R5: When `out_valid` is high, `out_gcd` equals the greatest common divisor of the accepted pair.
- R6: Let s be the number of subtraction steps that Euclid's subtractive loop needs for the pair (zero when the operands are equal or either one is zero). `out_valid` is then high after exactly s+1 rising edges that follow the handshake edge.
- R7: If either operand is zero, no subtraction is made. `out_valid` rises two edges after the handshake, and `out_gcd` shows the other operand, or 0 when both are zero.
- R8: Equal operands skip the loop. `out_valid` rises two edges after the handshake, with `out_gcd` equal to the operand.
- R9: While `out_valid` stays high, `out_gcd` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Engine takes the pair at this edge |
| in_a | input | W | First operand, loaded into x |
| in_b | input | W | Second operand, loaded into y |
| out_valid | output | 1 | Result present and held |
| out_gcd | output | W | Greatest common divisor |

## Verification
The handshake edge is the reference point. `in_ready` must be seen one cycle after `in_valid` is raised. `out_valid` must be low on the cycle after the handshake and must be high after exactly s+1 more edges, where the bench works out s itself with a software subtractive loop. The bench samples on falling edges and counts edges from the handshake, so a design that finishes one cycle early or late fails even when its value is right. Each held result is then watched for two more cycles for stability.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_XSUB,
    ST_YSUB,
    ST_DONE
  } gcd_state_e;

  // Moore control word: one enable and one source select per register.
  typedef struct packed {
    logic x_en;
    logic x_from_in;
    logic y_en;
    logic y_from_in;
    logic rv_en;
    logic rv_val;
  } gcd_ctl_t;

endpackage

// File: rtl/gcd_sub.sv
module gcd_sub #(
  parameter int W = 16
) (
  input  logic [W-1:0] minuend,
  input  logic [W-1:0] subtrahend,
  output logic [W-1:0] diff,
  output logic         no_borrow
);

  localparam int SW = W + 1;

  logic [SW-1:0] sum;

  // two's complement: m + ~s + 1, top bit is the carry (no borrow)
  assign sum       = {1'b0, minuend} + {1'b0, ~subtrahend} + SW'(1);
  assign diff      = sum[W-1:0];
  assign no_borrow = sum[SW-1];

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  gcd_ctl_t     ctl,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic         nx_gt,
  output logic         nx_eq,
  output logic         nx_zero,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic         rv_q
);

  localparam int LANES = 2;

  logic [W-1:0] x_nx, y_nx;
  logic [W-1:0] dxy_q, dyx_q;
  logic [W-1:0] lane_min  [LANES];
  logic [W-1:0] lane_sub  [LANES];
  logic [W-1:0] lane_diff [LANES];
  logic [LANES-1:0] lane_nb;

  // value each register takes at this edge
  always_comb begin
    x_nx = x_q;
    y_nx = y_q;
    if (ctl.x_en) x_nx = ctl.x_from_in ? op_a : dxy_q;
    if (ctl.y_en) y_nx = ctl.y_from_in ? op_b : dyx_q;
  end

  assign lane_min[0] = x_nx;
  assign lane_sub[0] = y_nx;
  assign lane_min[1] = y_nx;
  assign lane_sub[1] = x_nx;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gcd_sub #(.W(W)) u_sub (
      .minuend   (lane_min[g]),
      .subtrahend(lane_sub[g]),
      .diff      (lane_diff[g]),
      .no_borrow (lane_nb[g])
    );
  end

  // ordering only from the two carries
  assign nx_eq   = lane_nb[0] & lane_nb[1];
  assign nx_gt   = lane_nb[0] & ~lane_nb[1];
  assign nx_zero = (x_nx == '0) | (y_nx == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q   <= '0;
      y_q   <= '0;
      dxy_q <= '0;
      dyx_q <= '0;
      rv_q  <= 1'b0;
    end else begin
      x_q   <= x_nx;
      y_q   <= y_nx;
      dxy_q <= lane_diff[0];
      dyx_q <= lane_diff[1];
      if (ctl.rv_en) rv_q <= ctl.rv_val;
    end
  end

endmodule

// File: rtl/gcd_ctrl.sv
module gcd_ctrl
  import gcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     nx_gt,
  input  logic     nx_eq,
  input  logic     nx_zero,
  output gcd_ctl_t ctl,
  output logic     take
);

  gcd_state_e st_q, st_nx;

  always_comb begin
    st_nx = st_q;
    unique case (st_q)
      ST_IDLE: st_nx = start ? ST_LOAD : ST_IDLE;
      ST_LOAD, ST_XSUB, ST_YSUB: begin
        if (nx_eq || nx_zero) st_nx = ST_DONE;
        else if (nx_gt)       st_nx = ST_XSUB;
        else                  st_nx = ST_YSUB;
      end
      ST_DONE: st_nx = ST_IDLE;
      default: st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_nx;
  end

  // Moore outputs: state only
  always_comb begin
    ctl = '0;
    unique case (st_q)
      ST_LOAD: begin
        ctl.x_en      = 1'b1;
        ctl.x_from_in = 1'b1;
        ctl.y_en      = 1'b1;
        ctl.y_from_in = 1'b1;
        ctl.rv_en     = 1'b1;
        ctl.rv_val    = 1'b0;
      end
      ST_XSUB: ctl.x_en = 1'b1;
      ST_YSUB: ctl.y_en = 1'b1;
      ST_DONE: begin
        ctl.rv_en  = 1'b1;
        ctl.rv_val = 1'b1;
      end
      default: ctl = '0;
    endcase
  end

  assign take = (st_q == ST_LOAD);

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  output logic         out_valid,
  output logic [W-1:0] out_gcd
);

  gcd_ctl_t     ctl;
  logic         nx_gt, nx_eq, nx_zero;
  logic [W-1:0] x_q, y_q;

  gcd_ctrl u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (in_valid),
    .nx_gt  (nx_gt),
    .nx_eq  (nx_eq),
    .nx_zero(nx_zero),
    .ctl    (ctl),
    .take   (in_ready)
  );

  gcd_datapath #(.W(W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl    (ctl),
    .op_a   (in_a),
    .op_b   (in_b),
    .nx_gt  (nx_gt),
    .nx_eq  (nx_eq),
    .nx_zero(nx_zero),
    .x_q    (x_q),
    .y_q    (y_q),
    .rv_q   (out_valid)
  );

  // once done, x==y or one is zero, so OR yields the answer
  assign out_gcd = x_q | y_q;

endmodule

// File: rtl/gcd_engine_chk.sv
module gcd_engine_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         out_valid,
  input logic [W-1:0] out_gcd
);

  assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);

  // R3: ready only follows an idle cycle that saw valid
  assert_ready_after_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> ($past(in_valid) && !$past(in_ready)));

  assert_take_clears_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !out_valid);

  assert_zero_skip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && (in_a == '0 || in_b == '0)) |=> ##1 out_valid);

  assert_equal_skip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_a == in_b) |=> ##1 out_valid);

  assert_result_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(out_valid)) |-> $stable(out_gcd));

endmodule

bind gcd_engine gcd_engine_chk #(.W(W)) u_chk (.*);

// File: tb/tb_gcd_engine.sv
module tb_gcd_engine;

  localparam int W    = 16;
  localparam int NVEC = 12;
  localparam int WD   = 195000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0;
  logic [W-1:0] in_b = '0;
  logic         in_ready;
  logic         out_valid;
  logic [W-1:0] out_gcd;

  int n_checks = 0;
  int n_fail   = 0;

  // {a, b, expected gcd}
  localparam logic [3*W-1:0] VEC [NVEC] = '{
    {W'(48),    W'(18),    W'(6)},
    {W'(18),    W'(48),    W'(6)},
    {W'(7),     W'(7),     W'(7)},
    {W'(1),     W'(1),     W'(1)},
    {W'(0),     W'(9),     W'(9)},
    {W'(12),    W'(0),     W'(12)},
    {W'(0),     W'(0),     W'(0)},
    {W'(65535), W'(65535), W'(65535)},
    {W'(65535), W'(21845), W'(21845)},
    {W'(1024),  W'(768),   W'(256)},
    {W'(1),     W'(300),   W'(1)},
    {W'(65535), W'(1),     W'(1)}
  };

  gcd_engine #(.W(W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_a     (in_a),
    .in_b     (in_b),
    .out_valid(out_valid),
    .out_gcd  (out_gcd)
  );

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] g, output int steps);
    logic [W-1:0] x = a;
    logic [W-1:0] y = b;
    steps = 0;
    if (x != '0 && y != '0) begin
      while (x != y) begin
        if (x > y) x = x - y;
        else       y = y - x;
        steps++;
      end
    end
    g = x | y;
  endfunction

  task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                          input logic [W-1:0] exp_g, input bit poke);
    logic [W-1:0] mg;
    int s;
    int k;
    string rq;
    model(a, b, mg, s);
    check(mg == exp_g, "R5", "model vs table", int'(mg), int'(exp_g));
    rq = (a == '0 || b == '0) ? "R7" : (a == b) ? "R8" : "R5";
    @(negedge clk);
    in_a = a; in_b = b; in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R2", "ready one cycle after valid", int'(in_ready), 1);
    @(negedge clk);                       // handshake edge passed
    in_valid = 1'b0; in_a = ~a; in_b = '0;
    check(in_ready == 1'b0, "R2", "ready lasts one cycle", int'(in_ready), 0);
    check(out_valid == 1'b0, "R4", "valid cleared by load", int'(out_valid), 0);
    k = 0;
    while (!out_valid && k < s + 10) begin
      in_valid = (poke && k < 3);
      in_a = W'(k * 77 + 5);
      @(negedge clk);
      k++;
      if (poke && k <= 3)
        check(in_ready == 1'b0, "R3", "ready while busy", int'(in_ready), 0);
    end
    in_valid = 1'b0;
    check(k == s + 1, (rq == "R5") ? "R6" : rq, "edges to valid", k, s + 1);
    check(out_gcd == exp_g, rq, "result", int'(out_gcd), int'(exp_g));
    if (poke) check(out_gcd == exp_g, "R3", "result after busy poke", int'(out_gcd), int'(exp_g));
    repeat (2) @(negedge clk);
    check(out_valid == 1'b1 && out_gcd == exp_g, "R9", "result held",
          int'(out_gcd), int'(exp_g));
  endtask

  // watchdog
  initial begin
    repeat (WD) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got %0d cycles expected fewer", WD, WD);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [15:0] lfsr = 16'hACE1;
    logic [W-1:0] g;
    int s;

    // R1: reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b0 && out_valid == 1'b0, "R1", "during reset",
          int'({in_ready, out_valid}), 0);
    in_valid = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "valid ignored in reset", int'(in_ready), 0);
    in_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0 && out_valid == 1'b0, "R1", "after release",
          int'({in_ready, out_valid}), 0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      run_pair(VEC[i][3*W-1:2*W], VEC[i][2*W-1:W], VEC[i][W-1:0], 1'b0);
    end

    // pseudo-random small pairs against the model
    for (int i = 0; i < 10; i++) begin
      logic [W-1:0] ra, rb;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ra = W'(lfsr[7:0]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rb = W'(lfsr[11:4]);
      model(ra, rb, g, s);
      run_pair(ra, rb, g, 1'b0);
    end

    // R3: valid toggled while the loop runs
    run_pair(W'(200), W'(3), W'(1), 1'b1);

    // R1: reset drops a held result
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset clears held result", int'(out_valid), 0);
    rst_n = 1'b1;
    run_pair(W'(21), W'(14), W'(7), 1'b0);

    // R1: reset in the middle of a loop, then a clean pair
    @(negedge clk);
    in_a = W'(500); in_b = W'(1); in_valid = 1'b1;
    repeat (2) @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b0 && out_valid == 1'b0, "R1", "mid-loop reset",
          int'({in_ready, out_valid}), 0);
    run_pair(W'(35), W'(0), W'(35), 1'b0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule